// File: doc/BRIEF.md
# Low-Rate PHY Receive Deframer

This block sits after a demodulator that has already turned symbols into octets. It watches the incoming octet stream for the synchronization header. That header is a run of zero preamble octets followed by a one-octet start delimiter. Once the delimiter is found, the block treats the next octet as the PHY header. It writes that header, and then the payload, into a receive buffer through a simple write port. The header lands at buffer address 0, so a reader sees it as the first octet. Payload octet k lands at address k.

The low seven bits of the header give the payload length. The top bit is reserved, and it is stored exactly as it arrived. When the announced number of payload octets has been written, the block pulses an end flag and publishes the length. It then returns to hunting. The block aborts a frame with a one-cycle error pulse in two cases: a zero length, or a loss of sync reported by the demodulator while a frame is open.

The controller has three states:
- `ST_HUNT` counts zero octets and looks for the delimiter.
- `ST_HEADER` takes the length octet.
- `ST_PAYLOAD` stores payload octets.

The transitions are:
- HUNT→HEADER on a delimiter preceded by enough zeros.
- HEADER→PAYLOAD on a non-zero length.
- HEADER→HUNT on a zero length (error).
- PAYLOAD→HUNT on the last payload octet (end).
- HEADER/PAYLOAD→HUNT on sync loss (error).

Top module: `lrphy_rx_deframer`

## Requirements
- R1: After reset, buf_we, frame_start, frame_end and frame_err are 0, frame_len is 0, and the block is hunting.
- R2: A delimiter octet (parameter SFD, default 8'hA7) opens a frame only if at least PRE_MIN (default 1) zero octets arrived directly before it; any other accepted octet in between, and a delimiter with no preceding zero, leave the block hunting.
- R3: The octet accepted after the delimiter is written at address 0 with all 8 bits unchanged (bit 7 included), with frame_start high in the same cycle as that write, one clock after the octet was accepted.
- R4: The k-th accepted payload octet is written at address k, one clock after acceptance; cycles with in_valid low write nothing and do not advance the frame.
- R5: The payload length is header bits [6:0]; the write of payload octet number length carries frame_end and frame_len = length in that cycle, after which the block hunts and later octets are not written.
- R6: A header whose bits [6:0] are 0 gives a frame_err pulse one clock later, writes nothing, and returns the block to hunting.
- R7: sync_lost high while in ST_HEADER or ST_PAYLOAD gives a frame_err pulse one clock later, with no frame_end; the octet offered in that cycle is dropped, and the block hunts.
- R8: sync_lost while hunting clears the zero-octet run, so a delimiter right after it does not open a frame.
- R9: frame_len changes only in a cycle where frame_end is high.
- R10: A length of 127 writes the header plus payload addresses 1 through 127 and ends normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | in_octet carries a received octet this cycle |
| in_octet | input | 8 | Received octet from the demodulator |
| sync_lost | input | 1 | Demodulator lost symbol synchronization |
| buf_we | output | 1 | Receive-buffer write strobe |
| buf_addr | output | LEN_W | Receive-buffer write address (0 = header) |
| buf_wdata | output | 8 | Receive-buffer write data |
| frame_len | output | LEN_W | Length of the last completed frame |
| frame_start | output | 1 | Pulse with the header write |
| frame_end | output | 1 | Pulse with the last payload write |
| frame_err | output | 1 | Pulse on a zero length or sync loss inside a frame |

## Verification
The hardest case to reach from the ports is a sync loss that arrives in the exact cycle of the final payload octet. In that cycle the abort must win over completion, and frame_len must keep the previous frame's value. The stimulus reaches that cycle with a scripted octet sequence. The script counts the payload octets from the header value it sent and raises sync_lost together with the last one. The per-clock reference model independently predicts the error pulse and the absence of an end pulse. A second hard case is a delimiter whose zero run was broken by a non-zero octet or cleared by sync loss. Scripted preambles cover both of these cases.

// File: rtl/lrphy_rx_pkg.sv
package lrphy_rx_pkg;
    localparam int OCTET_W = 8;

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_HEADER  = 2'd1,
        ST_PAYLOAD = 2'd2
    } rx_state_e;
endpackage

// File: rtl/lrphy_rx_zero_run.sv
// Saturating counter of consecutive zero octets seen while hunting.
module lrphy_rx_zero_run #(
    parameter int PRE_MIN = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    input  logic is_zero,
    output logic armed
);
    localparam int CNT_W = (PRE_MIN < 1) ? 1 : $clog2(PRE_MIN + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(PRE_MIN);

    logic [CNT_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            run_q <= '0;
        end else if (step) begin
            if (!is_zero)
                run_q <= '0;
            else if (run_q != CNT_TOP)
                run_q <= run_q + 1'b1;
        end
    end

    assign armed = (run_q >= CNT_TOP);
endmodule

// File: rtl/lrphy_rx_pay_track.sv
// Tracks remaining payload octets and the next buffer address.
module lrphy_rx_pay_track #(
    parameter int LEN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] len,
    input  logic             step,
    output logic [LEN_W-1:0] addr,
    output logic             last
);
    logic [LEN_W-1:0] remain_q;
    logic [LEN_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            addr_q   <= '0;
        end else if (load) begin
            remain_q <= len;
            addr_q   <= LEN_W'(1);
        end else if (step) begin
            remain_q <= remain_q - 1'b1;
            addr_q   <= addr_q + 1'b1;
        end
    end

    assign addr = addr_q;
    assign last = (remain_q == LEN_W'(1));
endmodule

// File: rtl/lrphy_rx_deframer.sv
module lrphy_rx_deframer
    import lrphy_rx_pkg::*;
#(
    parameter logic [7:0] SFD     = 8'hA7,
    parameter int         PRE_MIN = 1,
    parameter int         LEN_W   = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_octet,
    input  logic             sync_lost,
    output logic             buf_we,
    output logic [LEN_W-1:0] buf_addr,
    output logic [7:0]       buf_wdata,
    output logic [LEN_W-1:0] frame_len,
    output logic             frame_start,
    output logic             frame_end,
    output logic             frame_err
);
    rx_state_e state_q, state_d;

    logic             accept;
    logic             hunt_step, sfd_hit, armed;
    logic             hdr_take, hdr_ok, hdr_zero;
    logic             pay_take, pay_last, abort;
    logic [LEN_W-1:0] hdr_len, pay_addr;

    assign accept    = in_valid && !sync_lost;
    assign hdr_len   = in_octet[LEN_W-1:0];
    assign hunt_step = accept && (state_q == ST_HUNT);
    assign sfd_hit   = hunt_step && (in_octet == SFD) && armed;
    assign hdr_take  = accept && (state_q == ST_HEADER);
    assign hdr_ok    = hdr_take && (hdr_len != '0);
    assign hdr_zero  = hdr_take && (hdr_len == '0);
    assign pay_take  = accept && (state_q == ST_PAYLOAD);
    assign abort     = sync_lost && (state_q != ST_HUNT);

    lrphy_rx_zero_run #(.PRE_MIN(PRE_MIN)) u_zero_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (sync_lost),
        .step    (hunt_step),
        .is_zero (in_octet == 8'h00),
        .armed   (armed)
    );

    lrphy_rx_pay_track #(.LEN_W(LEN_W)) u_pay_track (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (hdr_ok),
        .len   (hdr_len),
        .step  (pay_take),
        .addr  (pay_addr),
        .last  (pay_last)
    );

    always_comb begin
        state_d = state_q;
        if (abort) begin
            state_d = ST_HUNT;
        end else begin
            unique case (state_q)
                ST_HUNT:    if (sfd_hit) state_d = ST_HEADER;
                ST_HEADER:  if (hdr_take) state_d = hdr_ok ? ST_PAYLOAD : ST_HUNT;
                ST_PAYLOAD: if (pay_take && pay_last) state_d = ST_HUNT;
                default:    state_d = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_we      <= 1'b0;
            buf_addr    <= '0;
            buf_wdata   <= '0;
            frame_len   <= '0;
            frame_start <= 1'b0;
            frame_end   <= 1'b0;
            frame_err   <= 1'b0;
        end else begin
            buf_we      <= hdr_ok || pay_take;
            buf_addr    <= hdr_ok ? '0 : pay_addr;
            buf_wdata   <= in_octet;
            frame_start <= hdr_ok;
            frame_end   <= pay_take && pay_last;
            frame_err   <= abort || hdr_zero;
            if (pay_take && pay_last)
                frame_len <= pay_addr;
        end
    end
endmodule

// File: rtl/lrphy_rx_deframer_chk.sv
module lrphy_rx_deframer_chk #(
    parameter int LEN_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sync_lost,
    input logic             buf_we,
    input logic [LEN_W-1:0] buf_addr,
    input logic [LEN_W-1:0] frame_len,
    input logic             frame_start,
    input logic             frame_end,
    input logic             frame_err
);
    p_start_at_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (buf_we && buf_addr == '0));

    p_end_addr_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> (buf_we && buf_addr == frame_len && frame_len != '0));

    p_err_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> (!frame_end && !buf_we && !frame_start));

    p_drop_on_lost_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sync_lost |=> (!buf_we && !frame_end));

    p_len_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |-> $stable(frame_len));

    p_pulse_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({frame_start, frame_end, frame_err}) || (frame_start && frame_end));
endmodule

bind lrphy_rx_deframer lrphy_rx_deframer_chk #(.LEN_W(LEN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_lost   (sync_lost),
    .buf_we      (buf_we),
    .buf_addr    (buf_addr),
    .frame_len   (frame_len),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .frame_err   (frame_err)
);

// File: tb/lrphy_rx_deframer_tb.sv
module lrphy_rx_deframer_tb;
    localparam logic [7:0] SFD = 8'hA7;
    localparam int PRE_MIN = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_octet = 8'h00;
    logic       sync_lost = 1'b0;
    logic       buf_we, frame_start, frame_end, frame_err;
    logic [6:0] buf_addr, frame_len;
    logic [7:0] buf_wdata;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    lrphy_rx_deframer u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_octet(in_octet),
        .sync_lost(sync_lost), .buf_we(buf_we), .buf_addr(buf_addr),
        .buf_wdata(buf_wdata), .frame_len(frame_len), .frame_start(frame_start),
        .frame_end(frame_end), .frame_err(frame_err)
    );

    // Behavioural reference: mode 0 hunting, 1 expecting header, 2 payload.
    int   m_mode, m_zeros, m_rem, m_next;
    logic e_we, e_start, e_end, e_err;
    int   e_addr;
    logic [7:0] e_data;
    logic [6:0] e_len;

    always @(posedge clk) begin
        e_we = 0; e_start = 0; e_end = 0; e_err = 0;
        if (!rst_n) begin
            m_mode = 0; m_zeros = 0; m_rem = 0; m_next = 0;
            e_len = 0; e_addr = 0; e_data = 0;
        end else if (sync_lost) begin
            if (m_mode != 0) e_err = 1;
            m_mode = 0; m_zeros = 0;
        end else if (in_valid) begin
            if (m_mode == 0) begin
                if (in_octet == 8'h00) m_zeros++;
                else begin
                    if (in_octet == SFD && m_zeros >= PRE_MIN) m_mode = 1;
                    m_zeros = 0;
                end
            end else if (m_mode == 1) begin
                if (in_octet[6:0] == 0) begin
                    e_err = 1; m_mode = 0;
                end else begin
                    e_we = 1; e_start = 1; e_addr = 0; e_data = in_octet;
                    m_rem = in_octet[6:0]; m_next = 1; m_mode = 2;
                end
            end else begin
                e_we = 1; e_addr = m_next; e_data = in_octet;
                m_next++; m_rem--;
                if (m_rem == 0) begin
                    e_end = 1; e_len = 7'(m_next - 1); m_mode = 0;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            compared++;
            if (buf_we !== e_we || frame_start !== e_start || frame_end !== e_end ||
                frame_err !== e_err || frame_len !== e_len ||
                (e_we && (buf_addr !== 7'(e_addr) || buf_wdata !== e_data))) begin
                mismatched++;
                $display("FAIL %s t=%0t actual we=%b a=%0d d=%h s=%b e=%b x=%b len=%0d expected we=%b a=%0d d=%h s=%b e=%b x=%b len=%0d",
                         cur_req, $time, buf_we, buf_addr, buf_wdata, frame_start, frame_end,
                         frame_err, frame_len, e_we, e_addr, e_data, e_start, e_end, e_err, e_len);
            end
        end
    end

    task automatic put(input logic [7:0] b, input logic v = 1'b1, input logic sl = 1'b0);
        @(posedge clk); #1;
        in_octet = b; in_valid = v; sync_lost = sl;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) put(8'h00, 1'b0, 1'b0);
    endtask

    task automatic preamble(input int n);
        for (int i = 0; i < n; i++) put(8'h00);
        put(SFD);
    endtask

    task automatic payload(input int n, input logic [7:0] seed);
        for (int i = 0; i < n; i++) put(seed + 8'(i));
    endtask

    task automatic check_len(input logic [6:0] exp, input string tag);
        @(negedge clk);
        compared++;
        if (frame_len !== exp) begin
            mismatched++;
            $display("FAIL %s frame_len actual=%0d expected=%0d", tag, frame_len, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        cur_req = "R1";
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        idle(2);

        cur_req = "R2 R3 R4 R5";          // basic frame, 4-zero preamble
        preamble(4); put(8'h05); payload(5, 8'h10); idle(2);
        check_len(7'd5, "R5");

        cur_req = "R3";                   // reserved bit kept
        preamble(1); put(8'h83); payload(3, 8'hC0); idle(2);
        check_len(7'd3, "R3");

        cur_req = "R4";                   // valid gaps
        preamble(2); put(8'h04);
        put(8'h21); put(8'hEE, 1'b0); put(8'h22); put(8'hEE, 1'b0); put(8'hEE, 1'b0);
        put(8'h23); put(8'h24); idle(2);

        cur_req = "R2";                   // delimiter without zero, broken run
        put(8'h55); put(SFD); put(8'h03); payload(3, 8'h40);
        put(8'h00); put(8'h11); put(SFD); put(8'h02); payload(2, 8'h50); idle(2);
        check_len(7'd4, "R2");

        cur_req = "R6";                   // zero length
        preamble(3); put(8'h80); payload(3, 8'h60); idle(2);

        cur_req = "R7";                   // sync loss mid payload
        preamble(2); put(8'h06); payload(2, 8'h70); put(8'h72, 1'b1, 1'b1); payload(4, 8'h73); idle(2);
        check_len(7'd4, "R9");

        cur_req = "R7";                   // sync loss on the last payload octet
        preamble(1); put(8'h03); payload(2, 8'h90); put(8'h92, 1'b1, 1'b1); idle(2);
        check_len(7'd4, "R9");

        cur_req = "R7";                   // sync loss on the header
        preamble(1); put(8'h05, 1'b1, 1'b1); idle(2);

        cur_req = "R8";                   // sync loss while hunting
        put(8'h00); put(8'h00); put(8'h00, 1'b0, 1'b1); put(SFD); put(8'h02); payload(2, 8'hA0); idle(2);
        check_len(7'd4, "R8");

        cur_req = "R5";                   // trailing octets ignored
        preamble(1); put(8'h02); payload(2, 8'hB0); payload(3, 8'hB8); idle(2);
        check_len(7'd2, "R5");

        cur_req = "R10";                  // maximum length
        preamble(4); put(8'h7F); payload(127, 8'h01); idle(3);
        check_len(7'd127, "R10");

        cur_req = "R1";                   // reset returns to initial state
        @(posedge clk); #1 rst_n = 1'b0;
        idle(2);
        check_len(7'd0, "R1");
        #1 rst_n = 1'b1;
        idle(3);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule